// File: doc/BRIEF.md
# Byte-Wide One-Time-Writable Memory Array with Pin-Mode Decoding

This block is a synthesizable behavioural model of a byte-wide memory whose bits can only be cleared by writing. A bulk erase is the only way to set them back to one. A small set of control pins chooses the operating mode, as on a classic parallel read-only memory. These pins are an active-low chip select, an active-low output enable, and a flag that marks the output-enable pin as being at programming voltage. A second high-voltage flag, which stands for an overdriven address line, switches reads from the array to identification codes. The data output has a separate enable flag that stands for the high-impedance state. A standby flag reports the low-power deselected condition.

The model is cycle based. Read data is driven only after chip select and address have held for `ACC_LAT` clock edges in a row, and output enable has been low for `OE_LAT` edges in a row. A byte is programmed once for each low-going pulse on chip select while programming voltage is present. The new byte is the AND of the stored value and the data input. A synchronous erase input sets every byte to all ones. The control state machine has the states ST_STANDBY, ST_INHIBIT, ST_PROG, ST_OFF, ST_SETTLE and ST_DRIVE. The pins sampled at each edge choose the next state from any state:
- chip select high takes it to ST_INHIBIT when programming voltage is present, otherwise to ST_STANDBY.
- chip select low with programming voltage takes it to ST_PROG.
- chip select low with output enable high takes it to ST_OFF.
- chip select low with output enable low goes to ST_SETTLE while the latency counts are short, and to ST_DRIVE once both are met.

Top module: `otp_byte_store`

## Requirements
- R1: During and right after reset, dout_en is 0, dout is 0 and standby is 1, and every array byte reads 8'hFF.
- R2: An edge with ce_n=1 and vpp_hv=0 sets standby to 1 and dout_en to 0 after that edge, whatever oe_n is.
- R3: With ce_n=0, oe_n=0, vpp_hv=0 and sig_hv=0, once the latencies are met, dout carries the byte stored at addr and dout_en is 1.
- R4: An edge with ce_n=0, vpp_hv=0 and oe_n=1 sets dout_en to 0 and standby to 0 after that edge.
- R5: With vpp_hv=1, an edge with ce_n=0 whose previous edge saw ce_n=1 programs the byte at addr. Further edges with ce_n held low do not program again. dout_en stays 0 throughout.
- R6: Programming stores (old byte AND din), so bits can only go from 1 to 0.
- R7: An edge with ce_n=1 and vpp_hv=1 (inhibit) writes nothing and leaves dout_en=0 and standby=0.
- R8: dout_en rises only after ACC_LAT consecutive edges with ce_n=0, vpp_hv=0, the same addr and the same sig_hv. A change of any of these restarts the count.
- R9: dout_en also needs OE_LAT consecutive edges with oe_n=0. Leaving read mode drops dout_en at the next edge.
- R10: With sig_hv=1 in read mode, dout returns MFR_CODE when addr[0]=0 and DEV_CODE when addr[0]=1 in place of array data.
- R11: erase_all=1 at an edge sets every byte to 8'hFF. It takes priority over a program at the same edge.
- R12: dout is 0 whenever dout_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; restores the erased array |
| addr | input | AW | Byte address |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable (digital level of the shared pin) |
| vpp_hv | input | 1 | Shared pin is at programming voltage |
| sig_hv | input | 1 | Overdriven address line: identification code access |
| erase_all | input | 1 | Synchronous bulk erase to all ones |
| din | input | DW | Byte to program |
| dout | output | DW | Read data, 0 while not driven |
| dout_en | output | 1 | Output driven (0 stands for high impedance) |
| standby | output | 1 | Deselected low-power state |

## Verification
The assertions assume that every control pin and both voltage flags are clean digital levels, settled before each rising edge. They also assume that a voltage flag has meaning only through the mode it selects. The bench meets this by changing all inputs on the falling edge only. Its random phase holds the address most of the time, so the access latency is reached often. It keeps the erase and signature flags rare, so that reads, programs and inhibits each get a fair share of cycles.

// File: rtl/otpb_pkg.sv
package otpb_pkg;

    typedef enum logic [2:0] {
        M_STANDBY,
        M_INHIBIT,
        M_PROGRAM,
        M_DISABLE,
        M_READ,
        M_SIGNATURE
    } otpb_mode_e;

    typedef enum logic [2:0] {
        ST_STANDBY,
        ST_INHIBIT,
        ST_PROG,
        ST_OFF,
        ST_SETTLE,
        ST_DRIVE
    } otpb_state_e;

endpackage

// File: rtl/otpb_mode_decode.sv
module otpb_mode_decode
    import otpb_pkg::*;
(
    input  logic       ce_n,
    input  logic       oe_n,
    input  logic       vpp_hv,
    input  logic       sig_hv,
    output otpb_mode_e mode
);

    always_comb begin
        if (ce_n) begin
            mode = vpp_hv ? M_INHIBIT : M_STANDBY;
        end else if (vpp_hv) begin
            mode = M_PROGRAM;
        end else if (oe_n) begin
            mode = M_DISABLE;
        end else if (sig_hv) begin
            mode = M_SIGNATURE;
        end else begin
            mode = M_READ;
        end
    end

endmodule

// File: rtl/otpb_access_timer.sv
module otpb_access_timer #(
    parameter int AW      = 6,
    parameter int ACC_LAT = 4,
    parameter int OE_LAT  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          sig_hv,
    input  logic          sel_ok,
    input  logic          oe_ok,
    output logic          ready
);

    localparam int CW = $clog2(ACC_LAT + 1);
    localparam logic [CW-1:0] ACC_MAX = CW'(ACC_LAT);
    localparam logic [CW-1:0] OE_MIN  = CW'(OE_LAT);

    logic [CW-1:0] acnt_q, acnt_d;
    logic [CW-1:0] ocnt_q, ocnt_d;
    logic [AW-1:0] addr_q;
    logic          sig_q;
    logic          key_same;

    assign key_same = (addr == addr_q) && (sig_hv == sig_q);

    always_comb begin
        if (!sel_ok) begin
            acnt_d = '0;
        end else if ((acnt_q != '0) && key_same) begin
            acnt_d = (acnt_q == ACC_MAX) ? acnt_q : acnt_q + 1'b1;
        end else begin
            acnt_d = CW'(1);
        end

        if (!oe_ok) begin
            ocnt_d = '0;
        end else begin
            ocnt_d = (ocnt_q == ACC_MAX) ? ocnt_q : ocnt_q + 1'b1;
        end

        ready = (acnt_d >= ACC_MAX) && (ocnt_d >= OE_MIN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acnt_q <= '0;
            ocnt_q <= '0;
            addr_q <= '0;
            sig_q  <= 1'b0;
        end else begin
            acnt_q <= acnt_d;
            ocnt_q <= ocnt_d;
            addr_q <= addr;
            sig_q  <= sig_hv;
        end
    end

endmodule

// File: rtl/otpb_cell_array.sv
module otpb_cell_array #(
    parameter int            AW       = 6,
    parameter int            DW       = 8,
    parameter logic [DW-1:0] MFR_CODE = 'h20,
    parameter logic [DW-1:0] DEV_CODE = 'h42
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    input  logic          erase_all,
    input  logic          prog_strobe,
    input  logic          sig_sel,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];
    logic [DW-1:0] array_byte;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        logic [DW-1:0] byte_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q <= '1;
            end else if (erase_all) begin
                byte_q <= '1;
            end else if (prog_strobe && (addr == AW'(i))) begin
                byte_q <= byte_q & din;
            end
        end

        assign cells[i] = byte_q;
    end

    assign array_byte = cells[addr];
    assign rdata      = sig_sel ? (addr[0] ? DEV_CODE : MFR_CODE) : array_byte;

endmodule

// File: rtl/otp_byte_store.sv
module otp_byte_store
    import otpb_pkg::*;
#(
    parameter int            AW       = 6,
    parameter int            DW       = 8,
    parameter int            ACC_LAT  = 4,
    parameter int            OE_LAT   = 2,
    parameter logic [DW-1:0] MFR_CODE = 'h20,
    parameter logic [DW-1:0] DEV_CODE = 'h42
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          vpp_hv,
    input  logic          sig_hv,
    input  logic          erase_all,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_en,
    output logic          standby
);

    otpb_mode_e    mode;
    otpb_state_e   state_q, state_d;
    logic          ce_n_q;
    logic          sel_ok, oe_ok, ready;
    logic          prog_strobe;
    logic [DW-1:0] rdata;

    assign sel_ok      = !ce_n && !vpp_hv;
    assign oe_ok       = sel_ok && !oe_n;
    assign prog_strobe = (mode == M_PROGRAM) && ce_n_q;

    otpb_mode_decode u_decode (
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .vpp_hv (vpp_hv),
        .sig_hv (sig_hv),
        .mode   (mode)
    );

    otpb_access_timer #(
        .AW      (AW),
        .ACC_LAT (ACC_LAT),
        .OE_LAT  (OE_LAT)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (addr),
        .sig_hv (sig_hv),
        .sel_ok (sel_ok),
        .oe_ok  (oe_ok),
        .ready  (ready)
    );

    otpb_cell_array #(
        .AW       (AW),
        .DW       (DW),
        .MFR_CODE (MFR_CODE),
        .DEV_CODE (DEV_CODE)
    ) u_cells (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr        (addr),
        .din         (din),
        .erase_all   (erase_all),
        .prog_strobe (prog_strobe),
        .sig_sel     (mode == M_SIGNATURE),
        .rdata       (rdata)
    );

    // next-state selection
    always_comb begin
        unique case (mode)
            M_STANDBY:   state_d = ST_STANDBY;
            M_INHIBIT:   state_d = ST_INHIBIT;
            M_PROGRAM:   state_d = ST_PROG;
            M_DISABLE:   state_d = ST_OFF;
            M_READ,
            M_SIGNATURE: state_d = ready ? ST_DRIVE : ST_SETTLE;
            default:     state_d = ST_STANDBY;
        endcase
    end

    // state register and chip-select history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STANDBY;
            ce_n_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            ce_n_q  <= ce_n;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout    <= '0;
            dout_en <= 1'b0;
            standby <= 1'b1;
        end else begin
            dout_en <= (state_d == ST_DRIVE);
            dout    <= (state_d == ST_DRIVE) ? rdata : '0;
            standby <= (state_d == ST_STANDBY);
        end
    end

endmodule

// File: rtl/otp_byte_store_chk.sv
module otp_byte_store_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce_n,
    input logic          oe_n,
    input logic          vpp_hv,
    input logic [DW-1:0] dout,
    input logic          dout_en,
    input logic          standby
);

    p_standby_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && !vpp_hv) |=> (standby && !dout_en));

    p_oe_high_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !vpp_hv && oe_n) |=> (!dout_en && !standby));

    p_prog_no_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && vpp_hv) |=> !dout_en);

    p_inhibit_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && vpp_hv) |=> (!dout_en && !standby));

    p_drive_needs_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_en) |-> $past(!ce_n && !oe_n && !vpp_hv));

    p_idle_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (dout == '0));

endmodule

bind otp_byte_store otp_byte_store_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .vpp_hv  (vpp_hv),
    .dout    (dout),
    .dout_en (dout_en),
    .standby (standby)
);

// File: tb/sim_otp_byte_store.sv
`timescale 1ns/1ps
module sim_otp_byte_store;

    localparam int AW  = 6;
    localparam int DW  = 8;
    localparam int ACC = 4;
    localparam int OEL = 2;
    localparam logic [7:0] MFR = 8'h20;
    localparam logic [7:0] DEV = 8'h42;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          ce_n = 1'b1, oe_n = 1'b1, vpp_hv = 1'b0, sig_hv = 1'b0, erase_all = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_en, standby;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    string req = "R1";

    // reference model state
    logic [7:0]    m_mem [DEPTH];
    int            acnt, ocnt;
    logic [AW-1:0] kaddr;
    logic          ksig, pce;
    logic          exp_en, exp_sb;
    logic [7:0]    exp_d;

    always #2.5 clk = ~clk;

    otp_byte_store #(
        .AW(AW), .DW(DW), .ACC_LAT(ACC), .OE_LAT(OEL), .MFR_CODE(MFR), .DEV_CODE(DEV)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
        .vpp_hv(vpp_hv), .sig_hv(sig_hv), .erase_all(erase_all), .din(din),
        .dout(dout), .dout_en(dout_en), .standby(standby)
    );

    task automatic model_edge();
        logic       sel;
        logic [7:0] rd;
        sel = !ce_n && !vpp_hv;
        if (!sel) acnt = 0;
        else if (acnt != 0 && addr == kaddr && sig_hv == ksig) acnt = (acnt < ACC) ? acnt + 1 : ACC;
        else acnt = 1;
        kaddr = addr;
        ksig  = sig_hv;
        if (sel && !oe_n) ocnt = (ocnt < ACC) ? ocnt + 1 : ACC;
        else ocnt = 0;
        rd = sig_hv ? (addr[0] ? DEV : MFR) : m_mem[addr];
        exp_en = sel && !oe_n && acnt >= ACC && ocnt >= OEL;
        exp_d  = exp_en ? rd : 8'h00;
        exp_sb = ce_n && !vpp_hv;
        if (erase_all) begin
            for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
        end else if (!ce_n && vpp_hv && pce) begin
            m_mem[addr] = m_mem[addr] & din;
        end
        pce = ce_n;
    endtask

    task automatic compare();
        total++;
        if (dout_en !== exp_en || dout !== exp_d || standby !== exp_sb) begin
            bad++;
            $display("FAIL %s: en/dout/sb act=%b/%h/%b exp=%b/%h/%b",
                     req, dout_en, dout, standby, exp_en, exp_d, exp_sb);
        end
    endtask

    task automatic check_val(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic pins(input logic c, input logic o, input logic v, input logic s,
                        input logic e, input logic [AW-1:0] a, input logic [7:0] d);
        ce_n = c; oe_n = o; vpp_hv = v; sig_hv = s; erase_all = e; addr = a; din = d;
    endtask

    task automatic read_byte(input logic [AW-1:0] a, input logic s, output logic [7:0] val);
        pins(1'b0, 1'b0, 1'b0, s, 1'b0, a, 8'h00);
        for (int i = 0; i < ACC + 1; i++) step();
        val = dout;
    endtask

    task automatic program_pulse(input logic [AW-1:0] a, input logic [7:0] d);
        pins(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, a, d);
        step();
        pins(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, a, d);
        step();
        din = 8'h00;                    // R5: held low, no second write
        step();
        step();
        pins(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, a, 8'h00);
        step();
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
        acnt = 0; ocnt = 0; kaddr = '0; ksig = 1'b0; pce = 1'b1;
        exp_en = 1'b0; exp_d = 8'h00; exp_sb = 1'b1;

        // R1: reset state
        repeat (3) @(negedge clk);
        req = "R1";
        compare();
        rst_n = 1'b1;
        @(negedge clk);
        req = "R2";
        pins(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'd5, 8'h00);
        step();

        // R3/R8: latency of a read from standby
        req = "R8";
        pins(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd5, 8'h00);
        for (int i = 0; i < ACC - 1; i++) step();
        check_val("R8 early", dout_en, 0);
        step();
        check_val("R8 ready", dout_en, 1);
        check_val("R1 erased byte", dout, 8'hFF);
        // R8: address change restarts the count
        addr = 6'd9;
        step();
        check_val("R8 restart", dout_en, 0);
        for (int i = 0; i < ACC - 1; i++) step();
        check_val("R3 read new addr", dout_en, 1);

        // R5/R6: program twice, AND result
        req = "R5";
        program_pulse(6'd5, 8'hA5);
        read_byte(6'd5, 1'b0, v);
        check_val("R5 programmed", v, 8'hA5);
        req = "R6";
        program_pulse(6'd5, 8'h3C);
        read_byte(6'd5, 1'b0, v);
        check_val("R6 and", v, 8'h24);

        // R4: output disable
        req = "R4";
        oe_n = 1'b1;
        step();
        check_val("R4 hiz", dout_en, 0);
        // R9: oe falls after address has settled
        req = "R9";
        for (int i = 0; i < ACC + 1; i++) step();
        oe_n = 1'b0;
        for (int i = 0; i < OEL - 1; i++) step();
        check_val("R9 early", dout_en, 0);
        step();
        check_val("R9 ready", dout_en, 1);

        // R2: standby with oe low and high
        req = "R2";
        pins(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'd5, 8'h00);
        step();
        check_val("R2 standby", standby, 1);
        oe_n = 1'b1;
        step();

        // R7: inhibit writes nothing
        req = "R7";
        pins(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 6'd7, 8'h00);
        repeat (3) step();
        check_val("R7 standby low", standby, 0);
        read_byte(6'd7, 1'b0, v);
        check_val("R7 untouched", v, 8'hFF);

        // R10: signature codes
        req = "R10";
        read_byte(6'd0, 1'b1, v);
        check_val("R10 mfr", v, MFR);
        read_byte(6'd1, 1'b1, v);
        check_val("R10 dev", v, DEV);

        // R11: erase beats a program at the same edge
        req = "R11";
        pins(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 6'd6, 8'h00);
        step();
        pins(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 6'd6, 8'h00);
        step();
        pins(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 6'd6, 8'h00);
        step();
        read_byte(6'd6, 1'b0, v);
        check_val("R11 erase priority", v, 8'hFF);
        read_byte(6'd5, 1'b0, v);
        check_val("R11 erased", v, 8'hFF);

        // random phase, every cycle compared (R3 R12)
        req = "R12";
        for (int n = 0; n < 600; n++) begin
            ce_n      = ($urandom_range(99) < 25);
            oe_n      = ($urandom_range(99) < 25);
            vpp_hv    = ($urandom_range(99) < 15);
            sig_hv    = ($urandom_range(99) < 8);
            erase_all = ($urandom_range(99) < 2);
            din       = 8'($urandom_range(255));
            if ($urandom_range(99) < 20) addr = AW'($urandom_range(7));
            step();
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule